// File: doc/BRIEF.md
# Soft Mute Gain Ramp for Multichannel PCM

This block scales a group of parallel 24-bit two's complement audio channels by a single shared gain that moves in steps of one per sample frame. While the mute request is high, the gain falls from unity to zero. Once the request drops, the gain rises back to unity at the same per-frame rate. The gain moves only on the frame strobe. The block therefore sits in the sample path, before interpolation, and is clocked by the system clock. One strobe marks each new frame.

The ramp length depends on a 2-bit speed code. In normal speed a full ramp takes a base number of frames (1024 by default). In double speed it takes twice that, and in quad speed four times that. If the request changes in the middle of a ramp, the gain turns around from its present value and does not restart. The gain is a counter in quarter-step units with a full scale of 4 × BASE_FRAMES. Each output sample is the input times the counter divided by the full scale, truncated toward zero.

Top module: `mute_ramp_atten`

## Requirements
- R1: While reset is low and after reset, `pcm_valid` is 0, `pcm_out` is all zeros and the gain is unity, so the first frame with the request low passes its samples unchanged.
- R2: `pcm_valid` is high for exactly the one cycle after each cycle in which `frame_stb` is high.
- R3: For every frame, each channel output equals input × G / (4 × BASE_FRAMES), truncated toward zero. G is the gain counter value before that frame's update.
- R4: At unity gain (G = 4 × BASE_FRAMES) every output sample equals its input sample bit for bit, including the most negative value.
- R5: With speed code 00 (normal), a request held high takes G from unity to 0 in exactly BASE_FRAMES frames, falling by 4 per frame.
- R6: With speed code 01 (double), G moves by 2 per frame, so a full ramp lasts 2 × BASE_FRAMES frames. With codes 10 and 11 (quad), G moves by 1 per frame, so a full ramp lasts 4 × BASE_FRAMES frames.
- R7: With the request low, G climbs back to unity over the same frame count as the downward ramp for the same speed code.
- R8: A release in the middle of a downward ramp reverses G from its current value at the same per-frame rate. A request in the middle of an upward ramp reverses it the same way.
- R9: G holds at 0 while the request stays high, and holds at unity while the request stays low.
- R10: While G is 0, every channel output is exactly zero.
- R11: All channels are scaled by the same G in the same frame.
- R12: Without `frame_stb`, neither G nor `pcm_out` changes, whatever `pcm_in`, `mute_req` and `speed_mode` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse marking a new sample frame |
| mute_req | input | 1 | 1 = ramp toward silence, 0 = ramp toward unity; sampled on the strobe |
| speed_mode | input | 2 | 00 normal, 01 double, 10 and 11 quad |
| pcm_in | input | NUM_CH×DATA_W | Input samples; channel k at bits [k×DATA_W +: DATA_W] |
| pcm_out | output | NUM_CH×DATA_W | Scaled samples, same lane layout |
| pcm_valid | output | 1 | High for one cycle when `pcm_out` holds a new frame |

## Verification
On a single strobe edge, the block scales the frame by the old gain and also moves the gain. It is most exposed when the mute request flips on the frame where the counter would reach a bound. The bench provokes this in two places. It releases the request on the frame just before the gain would hit zero, and it ramps a partly muted gain up onto the unity boundary and holds it there. A scoreboard model predicts each frame, and that prediction judges the outcome. Channel 0 always carries full-scale positive input, so the gain itself can be read frame by frame at the outputs.

// File: rtl/smr_pkg.sv
// Shared definitions for the soft mute gain ramp.
// Assumes the gain counter is kept in quarter steps of the normal-speed rate.
package smr_pkg;

    // Speed code carried on speed_mode.
    typedef enum logic [1:0] {
        SPD_NORMAL = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_QUAD_B = 2'b11
    } speed_e;

    // Sub-step resolution: the counter carries this many fraction bits.
    localparam int unsigned STEP_FRAC_BITS = 2;

    // Counter increment per frame for a speed code, in quarter units.
    function automatic int unsigned step_of(input speed_e s);
        case (s)
            SPD_NORMAL: return 4;
            SPD_DOUBLE: return 2;
            default:    return 1;
        endcase
    endfunction

endpackage

// File: rtl/smr_gain_ramp.sv
// Gain counter for the soft mute.
// Moves once per frame strobe: down toward 0 while muted, up toward FULL otherwise.
// The step size follows the speed code. The counter saturates at both ends.
// Assumes FULL is a multiple of 4, so every step size lands exactly on the bounds.
module smr_gain_ramp #(
    parameter int unsigned FULL  = 4096,
    parameter int unsigned CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic             mute_req,
    input  logic [1:0]       speed_mode,
    output logic [CNT_W-1:0] gain
);
    import smr_pkg::*;

    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(FULL);

    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] headroom;
    logic [CNT_W-1:0] gain_nxt;

    // Select the per-frame step and the distance left to unity.
    always_comb begin
        step     = CNT_W'(step_of(speed_e'(speed_mode)));
        headroom = FULL_C - gain;
    end

    // Next gain value: saturating move in the requested direction.
    always_comb begin
        if (mute_req) begin
            gain_nxt = (gain > step) ? (gain - step) : '0;
        end else begin
            gain_nxt = (headroom > step) ? (gain + step) : FULL_C;
        end
    end

    // Gain register: unity after reset, updated only on a frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain <= FULL_C;
        end else if (frame_stb) begin
            gain <= gain_nxt;
        end
    end

    // R5/R6: a muted frame lowers a nonzero gain.
    a_r5_falls_when_muted: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && mute_req && gain != '0) |=> (gain < $past(gain)));

    // R8: an unmuted frame below unity raises the gain from where it was.
    a_r8_rises_from_current: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !mute_req && gain != FULL_C) |=> (gain > $past(gain)));

    // R9: the bounds hold while the request keeps its level.
    a_r9_hold_min: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && mute_req && gain == '0) |=> (gain == '0));
    a_r9_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !mute_req && gain == FULL_C) |=> (gain == FULL_C));

    // R12: no movement without a strobe.
    a_r12_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(gain));

    // R6: one frame moves the gain by at most four quarter units.
    a_r6_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> ((gain >= $past(gain)) ? (gain - $past(gain) <= 4)
                                             : ($past(gain) - gain <= 4)));

    // R3: gain never leaves its range.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r3_gain_range: assert (gain <= FULL_C);
        end
    end

endmodule

// File: rtl/smr_chan_scale.sv
// One channel multiplier: sample times gain / 2**SHIFT, truncated toward zero.
// Registers the result on load and holds it otherwise.
// Assumes gain <= 2**SHIFT, so the result always fits in DATA_W bits.
module smr_chan_scale #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned CNT_W  = 13,
    parameter int unsigned SHIFT  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  gain,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int unsigned PW = DATA_W + CNT_W + 1;
    localparam logic [CNT_W-1:0] UNITY = CNT_W'(2 ** SHIFT);

    logic signed [DATA_W-1:0] din_s;
    logic signed [PW-1:0]     din_x;
    logic signed [PW-1:0]     gain_x;
    logic signed [PW-1:0]     prod;
    logic signed [PW-1:0]     bias;
    logic signed [PW-1:0]     scaled;

    // Widen both operands as signed values and form the product.
    always_comb begin
        din_s  = $signed(din);
        din_x  = PW'(din_s);
        gain_x = $signed(PW'({1'b0, gain}));
        prod   = din_x * gain_x;
    end

    // Round a negative product toward zero before the arithmetic shift.
    always_comb begin
        bias   = prod[PW-1] ? $signed(PW'(2 ** SHIFT - 1)) : '0;
        scaled = (prod + bias) >>> SHIFT;
    end

    // Output register: cleared on reset, loaded once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= scaled[DATA_W-1:0];
        end
    end

    // R3: the dropped upper bits of the result are pure sign extension.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r3_no_overflow: assert (scaled[PW-1:DATA_W] == {(PW-DATA_W){scaled[DATA_W-1]}});
        end
    end

    // R10: zero gain gives zero output.
    a_r10_zero_at_min: assert property (@(posedge clk) disable iff (!rst_n)
        (load && gain == '0) |=> (dout == '0));

    // R4: unity gain is transparent.
    a_r4_unity_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (load && gain == UNITY) |=> (dout == $past(din)));

endmodule

// File: rtl/mute_ramp_atten.sv
// Soft mute attenuator for NUM_CH parallel PCM channels.
// One shared gain ramp drives every channel. The output is registered one cycle after the strobe.
// Assumes frame_stb is a single-cycle pulse and BASE_FRAMES is a power of two.
module mute_ramp_atten #(
    parameter int unsigned NUM_CH      = 8,
    parameter int unsigned DATA_W      = 24,
    parameter int unsigned BASE_FRAMES = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_stb,
    input  logic                     mute_req,
    input  logic [1:0]               speed_mode,
    input  logic [NUM_CH*DATA_W-1:0] pcm_in,
    output logic [NUM_CH*DATA_W-1:0] pcm_out,
    output logic                     pcm_valid
);
    import smr_pkg::*;

    localparam int unsigned FULL  = BASE_FRAMES * (2 ** STEP_FRAC_BITS);
    localparam int unsigned SHIFT = $clog2(FULL);
    localparam int unsigned CNT_W = SHIFT + 1;

    logic [CNT_W-1:0] gain;

    // Shared gain counter.
    smr_gain_ramp #(
        .FULL  (FULL),
        .CNT_W (CNT_W)
    ) u_ramp (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .mute_req   (mute_req),
        .speed_mode (speed_mode),
        .gain       (gain)
    );

    // R11: one multiplier per channel, all fed the same gain.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        smr_chan_scale #(
            .DATA_W (DATA_W),
            .CNT_W  (CNT_W),
            .SHIFT  (SHIFT)
        ) u_scale (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (frame_stb),
            .gain  (gain),
            .din   (pcm_in[k*DATA_W +: DATA_W]),
            .dout  (pcm_out[k*DATA_W +: DATA_W])
        );
    end

    // Valid flag: marks the cycle after each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcm_valid <= 1'b0;
        end else begin
            pcm_valid <= frame_stb;
        end
    end

    // R2: valid follows the strobe by exactly one cycle.
    a_r2_valid_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> pcm_valid);
    a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> !pcm_valid);

    // R12: outputs hold between frames.
    a_r12_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(pcm_out));

endmodule

// File: tb/mute_ramp_atten_tb.sv
// Scoreboard bench: the driver predicts each frame, the monitor compares on pcm_valid.
module mute_ramp_atten_tb;
    localparam int NCH  = 8;
    localparam int DW   = 24;
    localparam int BW   = NCH * DW;
    localparam int FULL = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_stb = 1'b0;
    logic          mute_req = 1'b0;
    logic [1:0]    speed_mode = 2'b00;
    logic [BW-1:0] pcm_in = '0;
    logic [BW-1:0] pcm_out;
    logic          pcm_valid;

    int checks = 0;
    int errors = 0;
    int g_model = FULL;
    bit finished = 1'b0;
    logic [BW-1:0] exp_q[$];
    string         tag_q[$];

    always #5 clk = ~clk;

    mute_ramp_atten u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .mute_req   (mute_req),
        .speed_mode (speed_mode),
        .pcm_in     (pcm_in),
        .pcm_out    (pcm_out),
        .pcm_valid  (pcm_valid)
    );

    function automatic int chan_val(input int idx, input int ch);
        if (ch == 0) return 8388607;
        if (ch == 1) return -8388608;
        return ((idx * 7919 + ch * 100003) % 16777216) - 8388608;
    endfunction

    // Truncating division of the product gives rounding toward zero.
    function automatic int scale(input int v, input int g);
        longint p;
        p = longint'(v) * longint'(g);
        return int'(p / FULL);
    endfunction

    function automatic int step_for(input logic [1:0] sp);
        if (sp == 2'b00) return 4;
        if (sp == 2'b01) return 2;
        return 1;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [BW-1:0] act,
                         input logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one frame, with the prediction pushed to the scoreboard.
    task automatic send(input logic m, input logic [1:0] sp, input int idx, input string tag);
        logic [BW-1:0] v;
        logic [BW-1:0] e;
        int st;
        for (int ch = 0; ch < NCH; ch++) begin
            int x;
            x = chan_val(idx, ch);
            v[ch*DW +: DW] = x[DW-1:0];
            e[ch*DW +: DW] = scale(x, g_model) & 32'h00FF_FFFF;
        end
        @(negedge clk);
        frame_stb  = 1'b1;
        mute_req   = m;
        speed_mode = sp;
        pcm_in     = v;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        st = step_for(sp);
        if (m) g_model = (g_model > st) ? g_model - st : 0;
        else   g_model = (FULL - g_model > st) ? g_model + st : FULL;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    // Monitor: compare each produced frame with the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && pcm_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected valid", pcm_out, '0);
            end else begin
                logic [BW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(pcm_out == e, t, pcm_out, e);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        int n;
        logic [BW-1:0] held;
        // R1: reset state.
        repeat (3) @(negedge clk);
        check(pcm_valid == 1'b0, "R1 valid in reset", {{(BW-1){1'b0}}, pcm_valid}, '0);
        check(pcm_out == '0, "R1 output in reset", pcm_out, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pcm_out == '0 && !pcm_valid, "R1 state after reset", pcm_out, '0);
        n = 0;

        // R1/R4/R11: unity gain right after reset, several patterns.
        for (int i = 0; i < 6; i++) send(1'b0, 2'b00, n++, "R4 unity pass-through");
        // R2: valid is a single cycle after the strobe.
        @(negedge clk);
        check(!pcm_valid, "R2 valid single cycle", {{(BW-1){1'b0}}, pcm_valid}, '0);

        // R5/R3: full normal-speed mute, then hold at zero (R9, R10).
        for (int i = 0; i < 1024; i++) send(1'b1, 2'b00, n++, "R5 normal ramp down");
        for (int i = 0; i < 4; i++) send(1'b1, 2'b00, n++, "R10 zero at minimum");
        // R7: release back to unity over 1024 frames, then hold (R9).
        for (int i = 0; i < 1024; i++) send(1'b0, 2'b00, n++, "R7 normal ramp up");
        for (int i = 0; i < 4; i++) send(1'b0, 2'b00, n++, "R9 hold at unity");

        // R8: release partway down, climb from the current value.
        for (int i = 0; i < 300; i++) send(1'b1, 2'b00, n++, "R8 partial down");
        for (int i = 0; i < 310; i++) send(1'b0, 2'b00, n++, "R8 reverse up");
        // R8: release on the frame just before the gain would reach zero.
        for (int i = 0; i < 1023; i++) send(1'b1, 2'b00, n++, "R8 near zero");
        send(1'b0, 2'b00, n++, "R8 release at boundary");
        send(1'b1, 2'b00, n++, "R8 re-mute");
        for (int i = 0; i < 1030; i++) send(1'b0, 2'b00, n++, "R8 recover to unity");

        // R6: double speed full ramp and return.
        for (int i = 0; i < 2050; i++) send(1'b1, 2'b01, n++, "R6 double ramp down");
        for (int i = 0; i < 2050; i++) send(1'b0, 2'b01, n++, "R6 double ramp up");

        // R6: quad speed (code 10) full ramp, code 11 on the way back.
        for (int i = 0; i < 4098; i++) send(1'b1, 2'b10, n++, "R6 quad ramp down");
        for (int i = 0; i < 40; i++) send(1'b0, 2'b11, n++, "R6 quad code 11 up");

        // R12: no strobe, inputs wander, output and gain must hold.
        @(negedge clk);
        @(negedge clk);
        held = pcm_out;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            pcm_in = {NCH{24'h5A5A5A}} ^ BW'(i);
            mute_req = ~mute_req;
            speed_mode = 2'(i);
        end
        @(negedge clk);
        check(pcm_out == held && !pcm_valid, "R12 idle hold", pcm_out, held);
        send(1'b0, 2'b11, n++, "R12 gain unchanged by idle cycles");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 all frames produced", BW'(exp_q.size()), '0);
        finish_run();
    end
endmodule